// File: doc/BRIEF.md
# Rotating Read/Write Die Partition Dispatcher

This block sits between a page request source and an array of flash dies arranged as channels by ways. In each channel a single way is the write way at any time; every other way in that channel serves reads only. Writes are steered to the current write way of the channel they name. Reads to a read way go straight out. A read that lands on the current write way is never sent there. Instead, it becomes one rebuild read on each other way of the same channel, and those rebuild reads go to the front of the pending queue so that a downstream parity unit can reconstruct the page.

Requests wait in a small queue and leave one per cycle, from its head, only when the target die is idle. Each channel counts the writes its write die has taken. When every channel has reached a full erase block of writes, and no rebuild read is still waiting, the write way steps to the next way in every channel at once. After the last way it returns to way 0.

Top module: `rwpart_dispatch`

## Requirements
- R1: After reset, no command is issued, `write_way` is 0 and `rq_ready` is 1.
- R2: A read (`rq_write`=0) aimed at a way other than `write_way` is issued with the same channel and way, `cmd_write`=0 and `cmd_rebuild`=0, in the cycle after it is accepted when the queue was empty and the die idle.
- R3: A read aimed at the current write way is never issued to that way. Instead, NUM_WAY-1 rebuild reads (`cmd_rebuild`=1) are issued to the other ways of that channel in ascending way order, on cycles 2, 3, ... NUM_WAY after acceptance.
- R4: Rebuild reads go ahead of every request that was already queued behind the read that produced them.
- R5: A write (`rq_write`=1) is always issued to the current `write_way` of the channel it names, whatever way it names, with `cmd_write`=1 and `cmd_rebuild`=0, one cycle after acceptance on an empty queue.
- R6: Once every channel has issued at least BLK_PAGES writes since the last rotation, `write_way` becomes (`write_way`+1) mod NUM_WAY two cycles after the completing write is accepted, and per-channel counts restart. Until then it holds, even if one channel has issued more than BLK_PAGES.
- R7: No request is issued while `die_busy` bit (channel*NUM_WAY + way) of its target die is 1. It is issued in the cycle after that bit returns to 0.
- R8: `rq_ready` is 0 while QDEPTH-(NUM_WAY-2) requests are held. This keeps room for rebuild expansion, which is performed only when the queue can hold all of its reads. Queued requests leave in arrival order apart from R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_valid | input | 1 | Request present |
| rq_ready | output | 1 | Request accepted this cycle if valid |
| rq_ch | input | $clog2(NUM_CH) | Request channel |
| rq_way | input | $clog2(NUM_WAY) | Request way (ignored for writes) |
| rq_write | input | 1 | 1 = page write, 0 = page read |
| die_busy | input | NUM_CH*NUM_WAY | Busy flag per die, bit channel*NUM_WAY+way |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_ch | output | $clog2(NUM_CH) | Command channel |
| cmd_way | output | $clog2(NUM_WAY) | Command way |
| cmd_write | output | 1 | 1 = write command |
| cmd_rebuild | output | 1 | 1 = read issued for a rebuild |
| write_way | output | $clog2(NUM_WAY) | Current write way, shared by all channels |

## Verification
A request accepted at edge k, with the queue empty, leaves at edge k+1 as a direct read or write. A read that needs a rebuild is expanded at k+1 and its rebuild reads leave at k+2 through k+NUM_WAY. A rotation shows on `write_way` at edge k+2 after the completing write is accepted at edge k. A die released at edge r has its held request issued at r+1. The bench time-stamps every issued command with the edge count. It compares each stamp with the cycle predicted from these offsets, sampling half a period after the edge, and checks that no extra command appears in the windows where none is due.

// File: rtl/rwpart_pkg.sv
package rwpart_pkg;

    localparam int unsigned IDX_W = 8;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } pg_op_e;

    typedef struct packed {
        logic [IDX_W-1:0] ch;
        logic [IDX_W-1:0] way;
        pg_op_e           op;
        logic             rebuild;
    } pg_req_t;

    function automatic logic [IDX_W-1:0] step_way(input logic [IDX_W-1:0] cur,
                                                  input int unsigned n);
        return (int'(cur) == int'(n) - 1) ? '0 : cur + 1'b1;
    endfunction

    // j-th way of a channel, skipping the excluded way, ascending
    function automatic logic [IDX_W-1:0] sibling_way(input logic [IDX_W-1:0] skip,
                                                     input int unsigned j);
        return (j < int'(skip)) ? IDX_W'(j) : IDX_W'(j + 1);
    endfunction

endpackage

// File: rtl/rwpart_queue.sv
module rwpart_queue
    import rwpart_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned N_INS = 3,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  pg_req_t       push_e,
    input  logic          pop,
    input  logic          ins,
    input  pg_req_t       ins_e [N_INS],
    output pg_req_t       head,
    output logic [CW-1:0] count
);
    pg_req_t q  [DEPTH];
    pg_req_t nq [DEPTH];
    int      nc;

    always_comb begin
        nq = q;
        nc = int'(count);
        if (pop) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) nq[i] = nq[i+1];
            nc = nc - 1;
        end
        if (ins) begin
            for (int i = int'(DEPTH) - 1; i >= int'(N_INS); i--) nq[i] = nq[i-int'(N_INS)];
            for (int j = 0; j < int'(N_INS); j++) nq[j] = ins_e[j];
            nc = nc + int'(N_INS);
        end
        if (push) begin
            for (int i = 0; i < int'(DEPTH); i++)
                if (i == nc) nq[i] = push_e;
            nc = nc + 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) q[i] <= '0;
            count <= '0;
        end else begin
            q     <= nq;
            count <= CW'(nc);
        end
    end

    assign head = q[0];

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= int'(DEPTH));
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);

endmodule

// File: rtl/rwpart_rotator.sv
module rwpart_rotator #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned NUM_WAY   = 4,
    parameter int unsigned BLK_PAGES = 256,
    localparam int unsigned CHW      = $clog2(NUM_CH),
    localparam int unsigned WYW      = $clog2(NUM_WAY),
    localparam int unsigned BCW      = $clog2(BLK_PAGES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_fire,
    input  logic [CHW-1:0] wr_ch,
    input  logic           hold,
    output logic [WYW-1:0] write_way,
    output logic           rotate_now
);
    logic [NUM_CH-1:0] full;

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        logic [BCW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst || rotate_now)
                cnt <= '0;
            else if (wr_fire && int'(wr_ch) == g && int'(cnt) != int'(BLK_PAGES))
                cnt <= cnt + 1'b1;
        end
        assign full[g] = (int'(cnt) == int'(BLK_PAGES));
    end

    assign rotate_now = (&full) && !hold;

    always_ff @(posedge clk) begin
        if (rst)
            write_way <= '0;
        else if (rotate_now)
            write_way <= (int'(write_way) == int'(NUM_WAY) - 1) ? '0 : write_way + 1'b1;
    end

    p_rotate_step_r6: assert property (@(posedge clk) disable iff (rst)
        (write_way != $past(write_way)) |->
        (int'(write_way) == (int'($past(write_way)) + 1) % int'(NUM_WAY)));
    p_no_write_on_rotate_r6: assert property (@(posedge clk) disable iff (rst)
        rotate_now |-> !wr_fire);

endmodule

// File: rtl/rwpart_dispatch.sv
module rwpart_dispatch
    import rwpart_pkg::*;
#(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned NUM_WAY   = 4,
    parameter int unsigned BLK_PAGES = 256,
    parameter int unsigned QDEPTH    = 8,
    localparam int unsigned CHW      = $clog2(NUM_CH),
    localparam int unsigned WYW      = $clog2(NUM_WAY),
    localparam int unsigned NDIE     = NUM_CH * NUM_WAY,
    localparam int unsigned RB_N     = NUM_WAY - 1,
    localparam int unsigned NET      = NUM_WAY - 2,
    localparam int unsigned CAP      = QDEPTH - NET,
    localparam int unsigned CW       = $clog2(QDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rq_valid,
    output logic            rq_ready,
    input  logic [CHW-1:0]  rq_ch,
    input  logic [WYW-1:0]  rq_way,
    input  logic            rq_write,
    input  logic [NDIE-1:0] die_busy,
    output logic            cmd_valid,
    output logic [CHW-1:0]  cmd_ch,
    output logic [WYW-1:0]  cmd_way,
    output logic            cmd_write,
    output logic            cmd_rebuild,
    output logic [WYW-1:0]  write_way
);
    pg_req_t        head;
    pg_req_t        push_e;
    pg_req_t        ins_e [RB_N];
    logic [CW-1:0]  qcount;
    logic [CW-1:0]  rb_cnt;
    logic           rotate_now;
    logic           have_head, hits_ww, room, expand, fire, push;
    logic [CHW-1:0] head_ch;
    logic [WYW-1:0] head_way, tgt_way;
    int             die_idx;

    assign have_head = (qcount != '0);
    assign head_ch   = head.ch[CHW-1:0];
    assign head_way  = head.way[WYW-1:0];
    assign hits_ww   = !head.rebuild && head.op == OP_RD && head_way == write_way;
    assign room      = (int'(QDEPTH) - int'(qcount)) >= int'(NET);
    assign expand    = have_head && !rotate_now && hits_ww && room;
    assign tgt_way   = (head.op == OP_WR) ? write_way : head_way;
    assign die_idx   = int'(head_ch) * int'(NUM_WAY) + int'(tgt_way);
    assign fire      = have_head && !rotate_now && !hits_ww && !die_busy[die_idx];
    assign rq_ready  = (int'(qcount) < int'(CAP)) && !expand;
    assign push      = rq_valid && rq_ready;

    always_comb begin
        push_e.ch      = IDX_W'(rq_ch);
        push_e.way     = IDX_W'(rq_way);
        push_e.op      = rq_write ? OP_WR : OP_RD;
        push_e.rebuild = 1'b0;
    end

    for (genvar j = 0; j < int'(RB_N); j++) begin : g_rb
        always_comb begin
            ins_e[j].ch      = head.ch;
            ins_e[j].way     = sibling_way(head.way, j);
            ins_e[j].op      = OP_RD;
            ins_e[j].rebuild = 1'b1;
        end
    end

    rwpart_queue #(.DEPTH(QDEPTH), .N_INS(RB_N)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .push_e (push_e),
        .pop    (fire || expand),
        .ins    (expand),
        .ins_e  (ins_e),
        .head   (head),
        .count  (qcount)
    );

    rwpart_rotator #(.NUM_CH(NUM_CH), .NUM_WAY(NUM_WAY), .BLK_PAGES(BLK_PAGES)) u_rot (
        .clk        (clk),
        .rst        (rst),
        .wr_fire    (fire && head.op == OP_WR),
        .wr_ch      (head_ch),
        .hold       (rb_cnt != '0),
        .write_way  (write_way),
        .rotate_now (rotate_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_cnt <= '0;
        end else if (expand) begin
            rb_cnt <= rb_cnt + CW'(RB_N);
        end else if (fire && head.rebuild) begin
            rb_cnt <= rb_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid   <= 1'b0;
            cmd_ch      <= '0;
            cmd_way     <= '0;
            cmd_write   <= 1'b0;
            cmd_rebuild <= 1'b0;
        end else begin
            cmd_valid <= fire;
            if (fire) begin
                cmd_ch      <= head_ch;
                cmd_way     <= tgt_way;
                cmd_write   <= (head.op == OP_WR);
                cmd_rebuild <= head.rebuild;
            end
        end
    end

    logic [NDIE-1:0] cmd_sel;
    assign cmd_sel = NDIE'(1) << (int'(cmd_ch) * int'(NUM_WAY) + int'(cmd_way));

    p_read_avoids_write_way_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write) |-> cmd_way != write_way);
    p_write_on_write_way_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write) |-> (cmd_way == write_way && !cmd_rebuild));
    p_busy_respected_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (($past(die_busy) & cmd_sel) == '0));
    p_ready_cap_r8: assert property (@(posedge clk) disable iff (rst)
        rq_ready |-> int'(qcount) < int'(CAP));

endmodule

// File: tb/rwpart_dispatch_tb.sv
module rwpart_dispatch_tb;
    localparam int NCH = 4;
    localparam int NW  = 4;
    localparam int BLK = 4;
    localparam int QD  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rq_valid = 1'b0;
    logic rq_ready;
    logic [1:0] rq_ch = '0;
    logic [1:0] rq_way = '0;
    logic rq_write = 1'b0;
    logic [NCH*NW-1:0] die_busy = '0;
    logic cmd_valid, cmd_write, cmd_rebuild;
    logic [1:0] cmd_ch, cmd_way, write_way;

    always #2 clk = ~clk;

    rwpart_dispatch #(.NUM_CH(NCH), .NUM_WAY(NW), .BLK_PAGES(BLK), .QDEPTH(QD)) u_dut (
        .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_ready(rq_ready),
        .rq_ch(rq_ch), .rq_way(rq_way), .rq_write(rq_write), .die_busy(die_busy),
        .cmd_valid(cmd_valid), .cmd_ch(cmd_ch), .cmd_way(cmd_way),
        .cmd_write(cmd_write), .cmd_rebuild(cmd_rebuild), .write_way(write_way)
    );

    int cyc = 0;
    int ev_n = 0;
    int ev_cyc [512];
    int ev_ch  [512];
    int ev_way [512];
    int ev_wr  [512];
    int ev_rb  [512];
    int nchk = 0;
    int nfail = 0;
    int ww = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && cmd_valid && ev_n < 512) begin
            ev_cyc[ev_n] = cyc;
            ev_ch[ev_n]  = int'(cmd_ch);
            ev_way[ev_n] = int'(cmd_way);
            ev_wr[ev_n]  = int'(cmd_write);
            ev_rb[ev_n]  = int'(cmd_rebuild);
            ev_n = ev_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_ev(input int idx, input int ecyc, input int ch, input int way,
                            input int wr, input int rb, input string req);
        if (idx >= ev_n) begin
            check(1'b0, req, "missing command index", ev_n, idx + 1);
        end else begin
            check(ev_cyc[idx] == ecyc, req, "issue cycle", ev_cyc[idx], ecyc);
            check(ev_ch[idx] == ch && ev_way[idx] == way, req, "channel*16+way",
                  ev_ch[idx] * 16 + ev_way[idx], ch * 16 + way);
            check(ev_wr[idx] == wr && ev_rb[idx] == rb, req, "write*2+rebuild",
                  ev_wr[idx] * 2 + ev_rb[idx], wr * 2 + rb);
        end
    endtask

    task automatic send(input int ch, input int way, input bit wr, output int acc);
        bit got;
        got = 1'b0;
        @(negedge clk);
        rq_valid = 1'b1;
        rq_ch    = 2'(ch);
        rq_way   = 2'(way);
        rq_write = wr;
        while (!got) begin
            #1 got = rq_ready;
            @(negedge clk);
        end
        acc = cyc;
        rq_valid = 1'b0;
    endtask

    task automatic read_probe(input int ch, input int way);
        int base, acc, k;
        base = ev_n;
        send(ch, way, 1'b0, acc);
        repeat (6) @(negedge clk);
        #1;
        if (way != ww) begin
            check(ev_n - base == 1, "R2", "command count", ev_n - base, 1);
            check_ev(base, acc + 1, ch, way, 0, 0, "R2");
        end else begin
            check(ev_n - base == NW - 1, "R3", "rebuild count", ev_n - base, NW - 1);
            k = 0;
            for (int w = 0; w < NW; w++) begin
                if (w != way) begin
                    check_ev(base + k, acc + 2 + k, ch, w, 0, 1, "R3");
                    k++;
                end
            end
        end
    endtask

    task automatic write_probe(input int ch, input int named);
        int base, acc;
        base = ev_n;
        send(ch, named, 1'b1, acc);
        @(negedge clk);
        #1;
        check(ev_n - base == 1, "R5", "command count", ev_n - base, 1);
        check_ev(base, acc + 1, ch, ww, 1, 0, "R5");
    endtask

    task automatic write_round(input int r);
        int acc, n;
        for (int ch = 0; ch < NCH; ch++) begin
            n = (ch == 0 && r == 0) ? BLK + 2 : BLK;
            for (int i = 0; i < n; i++) begin
                if (!(ch == NCH - 1 && i == BLK - 1)) write_probe(ch, (ch + i) % NW);
            end
        end
        repeat (2) @(negedge clk);
        check(int'(write_way) == ww, "R6", "write way before last write", int'(write_way), ww);
        send(NCH - 1, 0, 1'b1, acc);
        @(negedge clk);
        check(int'(write_way) == ww, "R6", "write way one cycle after", int'(write_way), ww);
        #1 check_ev(ev_n - 1, acc + 1, NCH - 1, ww, 1, 0, "R5");
        @(negedge clk);
        check(int'(write_way) == (ww + 1) % NW, "R6", "write way after rotation",
              int'(write_way), (ww + 1) % NW);
        ww = (ww + 1) % NW;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int acc, base, r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(cmd_valid == 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
        check(write_way == '0, "R1", "write_way", int'(write_way), 0);
        check(rq_ready == 1'b1, "R1", "rq_ready", int'(rq_ready), 1);

        for (int ch = 0; ch < NCH; ch++)
            for (int w = 0; w < NW; w++) read_probe(ch, w);

        write_round(0);
        for (int ch = 0; ch < NCH; ch++)
            for (int w = 0; w < NW; w++) read_probe(ch, w);

        for (int r = 1; r < NW; r++) write_round(r);
        check(int'(write_way) == 0, "R6", "wrap to way 0", int'(write_way), 0);

        // R7: held while die busy, issued the cycle after release
        @(negedge clk);
        die_busy[2 * NW + 3] = 1'b1;
        base = ev_n;
        send(2, 3, 1'b0, acc);
        repeat (4) @(negedge clk);
        #1 check(ev_n == base, "R7", "commands while busy", ev_n - base, 0);
        @(negedge clk);
        die_busy = '0;
        r0 = cyc;
        @(negedge clk);
        #1 check_ev(base, r0 + 1, 2, 3, 0, 0, "R7");

        // R8 and R4: fill to the cap behind a busy die, then drain
        @(negedge clk);
        die_busy[0 * NW + 2] = 1'b1;
        base = ev_n;
        send(0, 2, 1'b0, acc);
        send(1, 0, 1'b0, acc);
        send(2, 1, 1'b0, acc);
        send(3, 2, 1'b0, acc);
        send(1, 3, 1'b0, acc);
        send(2, 2, 1'b0, acc);
        #1 check(rq_ready == 1'b0, "R8", "rq_ready at cap", int'(rq_ready), 0);
        check(ev_n == base, "R7", "commands while head busy", ev_n - base, 0);
        @(negedge clk);
        die_busy = '0;
        r0 = cyc;
        repeat (10) @(negedge clk);
        #1;
        check(ev_n - base == 8, "R8", "drained command count", ev_n - base, 8);
        check_ev(base + 0, r0 + 1, 0, 2, 0, 0, "R8");
        check_ev(base + 1, r0 + 3, 1, 1, 0, 1, "R4");
        check_ev(base + 2, r0 + 4, 1, 2, 0, 1, "R4");
        check_ev(base + 3, r0 + 5, 1, 3, 0, 1, "R4");
        check_ev(base + 4, r0 + 6, 2, 1, 0, 0, "R8");
        check_ev(base + 5, r0 + 7, 3, 2, 0, 0, "R8");
        check_ev(base + 6, r0 + 8, 1, 3, 0, 0, "R8");
        check_ev(base + 7, r0 + 9, 2, 2, 0, 0, "R8");
        check(rq_ready == 1'b1, "R8", "rq_ready after drain", int'(rq_ready), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule